// File: doc/BRIEF.md
# Presence-Detect Serial EEPROM Slave

This block is a 256-byte configuration memory that answers on a two-wire serial bus (I2C) as a slave. A memory module uses it to describe itself to the host. The block runs on a fast system clock and oversamples SCL and SDA. Both lines pass through a synchronizer, and the block detects bus edges and START/STOP conditions from the sampled values. SDA is open-drain. The block never drives it high. It only asserts an output enable that pulls the line low, and an external resistor raises it.

The device address is the fixed prefix `1010` followed by three board straps. After a write header, the first data byte sets the internal word pointer. Later bytes in the same write are stored at the pointer. A read header returns bytes from the pointer. The pointer steps by one after every data byte and wraps from 255 to 0. The lower 128 bytes are locked. Writes to them are acknowledged but have no effect. The upper 128 bytes hold user data. At reset the array is loaded from the `IMAGE` parameter, except for byte 63, which holds the modulo-256 sum of bytes 0 to 62.

Top module: `spd_eeprom`

## Requirements
- R1: While `rst_n` is low, and after it is released with no bus traffic, `sda_oe` is 0.
- R2: A header byte whose upper seven bits are `1010` followed by `strap_i[2]`, `strap_i[1]`, `strap_i[0]` (MSB first; bit 0 is R/W, 1 = read) is acknowledged by pulling SDA low in the ninth clock. Any other header is not acknowledged. After a mismatch, the block drives nothing until the next START.
- R3: A write header followed by a word-address byte, then a repeated START and a read header, returns the byte stored at that word address MSB first. At reset, byte i of the array is `IMAGE[8*i+7:8*i]`.
- R4: The word pointer advances by one after every data byte that is read or written, and wraps from 255 to 0. A read that follows a repeated START with no word address starts at the current pointer.
- R5: A data byte written to a word address from 128 to 255 is acknowledged and is returned by later reads of that address.
- R6: A data byte written to a word address from 0 to 127 is acknowledged, but the stored content of that address is unchanged.
- R7: Byte 63 reads as the sum modulo 256 of bytes 0 through 62 of `IMAGE`, whatever `IMAGE` holds at byte 63.
- R8: A START or STOP in the middle of a byte discards that byte with no write. After a START the next byte is decoded as a new header. After a STOP the block waits for a START. The word pointer keeps its value.
- R9: `sda_o` is always 0. `sda_oe` changes only while SCL is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock used to oversample the bus |
| rst_n | input | 1 | Synchronous active-low reset; reloads the array |
| scl_i | input | 1 | Serial clock from the bus master |
| sda_i | input | 1 | Sensed level of the shared data line |
| sda_o | output | 1 | Data output level, always low (open drain) |
| sda_oe | output | 1 | 1 pulls the data line low |
| strap_i | input | 3 | Board straps forming the low address bits |

## Verification
The assertions assume a well-behaved master. It changes SDA only while SCL is low, except when it makes a START or STOP. It holds each SCL phase for several system clocks, longer than the synchronizer delay. It never issues a STOP while the slave is acknowledging. The bench master holds each SCL phase for eight or more clocks and changes SDA a full quarter bit after SCL falls. Random addresses and data are drawn only inside legal transactions. The aborted bytes are placed so that the START or STOP falls between two data bits and never inside an acknowledge slot.

// File: rtl/spd_pkg.sv
// Shared definitions for the presence-detect EEPROM slave.
// Assumes a byte-wide array of SPD_DEPTH entries.
package spd_pkg;

    localparam int SPD_DEPTH   = 256;
    localparam int SPD_STRAP_W = 3;

    // Protocol phases of the transfer engine.
    typedef enum logic [2:0] {
        ST_IDLE,   // waiting for START
        ST_DEV,    // shifting in the header byte
        ST_DACK,   // acknowledging the header
        ST_WORD,   // shifting in the word address
        ST_WACK,   // acknowledging a received byte
        ST_WDAT,   // shifting in a data byte
        ST_RDAT,   // shifting out a data byte
        ST_RACK    // sampling the master acknowledge
    } spd_state_t;

    // Builds a plausible default content image, byte i at bits [8i+7:8i].
    function automatic logic [SPD_DEPTH*8-1:0] spd_default_image();
        logic [SPD_DEPTH*8-1:0] img;
        img = '0;
        for (int i = 0; i < SPD_DEPTH; i++) begin
            logic [7:0] b;
            if (i == 0)       b = 8'h80;
            else if (i == 1)  b = 8'h08;
            else if (i == 2)  b = 8'h07;
            else if (i < 63)  b = 8'(i * 11 + 5);
            else if (i < 128) b = 8'h00;
            else              b = 8'hFF;
            img[i*8 +: 8] = b;
        end
        return img;
    endfunction

endpackage

// File: rtl/spd_line_sync.sv
// Multi-stage synchronizer for asynchronous bus lines, plus one extra
// register that holds the previous synchronized value for edge detection.
// Assumes STAGES >= 2; reset value is the idle bus level (all ones).
module spd_line_sync #(
    parameter int WIDTH  = 2,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] d,
    output logic [WIDTH-1:0] q,
    output logic [WIDTH-1:0] q_prev
);

    logic [STAGES-1:0][WIDTH-1:0] pipe;

    // Shift the raw lines through the synchronizer chain.
    always_ff @(posedge clk) begin
        if (!rst_n) pipe <= '1;
        else        pipe <= {pipe[STAGES-2:0], d};
    end

    // Keep last cycle's synchronized value for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) q_prev <= '1;
        else        q_prev <= pipe[STAGES-1];
    end

    assign q = pipe[STAGES-1];

endmodule

// File: rtl/spd_store.sv
// Byte array with a write-locked lower region. At reset every byte is
// loaded from IMAGE, except byte CSUM_IDX, which gets the modulo-256 sum of
// the bytes below it. Assumes the read address is stable at each use.
module spd_store #(
    parameter int                     DEPTH        = spd_pkg::SPD_DEPTH,
    parameter int                     LOCKED_BYTES = 128,
    parameter int                     CSUM_IDX     = 63,
    parameter logic [DEPTH*8-1:0]     IMAGE        = spd_pkg::spd_default_image(),
    localparam int                    AW           = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [AW-1:0] addr,
    input  logic          wr_en,
    input  logic [7:0]    wr_data,
    output logic [7:0]    rd_data
);

    // Sum of the image bytes that precede the checksum slot.
    function automatic logic [7:0] head_sum(input logic [DEPTH*8-1:0] img);
        logic [7:0] acc;
        acc = '0;
        for (int i = 0; i < CSUM_IDX; i++) acc = acc + img[i*8 +: 8];
        return acc;
    endfunction

    localparam logic [7:0] CSUM = head_sum(IMAGE);

    logic [7:0] mem [DEPTH];
    logic       unlocked;

    assign unlocked = {1'b0, addr} >= (AW+1)'(LOCKED_BYTES);

    // Load the image on reset; store only into the unlocked region.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++)
                mem[i] <= (i == CSUM_IDX) ? CSUM : IMAGE[i*8 +: 8];
        end else if (wr_en && unlocked) begin
            mem[addr] <= wr_data;
        end
    end

    assign rd_data = mem[addr];

endmodule

// File: rtl/spd_xfer_fsm.sv
// Serial transfer engine: header decode, word pointer, byte receive and
// transmit, acknowledge handling. Works on events from synchronized bus
// lines. Assumes SDA changes only while SCL is low, except for START/STOP.
module spd_xfer_fsm #(
    parameter int         AW         = 8,
    parameter int         STRAP_W    = spd_pkg::SPD_STRAP_W,
    parameter logic [6-STRAP_W:0] DEV_PREFIX = '0
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               scl_rise,
    input  logic               scl_fall,
    input  logic               sda_s,
    input  logic               start_det,
    input  logic               stop_det,
    input  logic [STRAP_W-1:0] strap,
    input  logic [7:0]         rd_data,
    output logic [AW-1:0]      mem_addr,
    output logic               mem_we,
    output logic [7:0]         mem_wdata,
    output logic               sda_drive,
    output logic               idle_o
);
    import spd_pkg::*;

    spd_state_t    state;
    logic [3:0]    bitcnt;
    logic [7:0]    shreg;
    logic [AW-1:0] ptr;
    logic          rw;
    logic          m_ack;
    logic          byte_done;
    logic          hdr_match;

    assign byte_done = scl_fall && (bitcnt == 4'd8);
    assign hdr_match = (shreg[7:1] == {DEV_PREFIX, strap});

    // Advance the protocol on bus events; START/STOP override everything.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state     <= ST_IDLE;
            bitcnt    <= '0;
            shreg     <= '0;
            ptr       <= '0;
            rw        <= 1'b0;
            m_ack     <= 1'b0;
            sda_drive <= 1'b0;
        end else if (start_det) begin
            state     <= ST_DEV;
            bitcnt    <= '0;
            sda_drive <= 1'b0;
        end else if (stop_det) begin
            state     <= ST_IDLE;
            sda_drive <= 1'b0;
        end else begin
            case (state)
                ST_DEV, ST_WORD, ST_WDAT: begin
                    if (scl_rise) begin
                        shreg  <= {shreg[6:0], sda_s};
                        bitcnt <= bitcnt + 4'd1;
                    end else if (byte_done) begin
                        bitcnt <= '0;
                        if (state == ST_DEV) begin
                            if (hdr_match) begin
                                sda_drive <= 1'b1;
                                rw        <= shreg[0];
                                state     <= ST_DACK;
                            end else begin
                                state <= ST_IDLE;
                            end
                        end else begin
                            if (state == ST_WORD) ptr <= shreg[AW-1:0];
                            else                  ptr <= ptr + 1'b1;
                            sda_drive <= 1'b1;
                            state     <= ST_WACK;
                        end
                    end
                end
                ST_DACK: begin
                    if (scl_fall) begin
                        bitcnt <= '0;
                        if (rw) begin
                            shreg     <= rd_data;
                            sda_drive <= ~rd_data[7];
                            ptr       <= ptr + 1'b1;
                            state     <= ST_RDAT;
                        end else begin
                            sda_drive <= 1'b0;
                            state     <= ST_WORD;
                        end
                    end
                end
                ST_WACK: begin
                    if (scl_fall) begin
                        sda_drive <= 1'b0;
                        bitcnt    <= '0;
                        state     <= ST_WDAT;
                    end
                end
                ST_RDAT: begin
                    if (scl_fall) begin
                        if (bitcnt == 4'd7) begin
                            sda_drive <= 1'b0;
                            state     <= ST_RACK;
                        end else begin
                            shreg     <= {shreg[6:0], 1'b0};
                            sda_drive <= ~shreg[6];
                            bitcnt    <= bitcnt + 4'd1;
                        end
                    end
                end
                ST_RACK: begin
                    if (scl_rise) begin
                        m_ack <= ~sda_s;
                    end else if (scl_fall) begin
                        bitcnt <= '0;
                        if (m_ack) begin
                            shreg     <= rd_data;
                            sda_drive <= ~rd_data[7];
                            ptr       <= ptr + 1'b1;
                            state     <= ST_RDAT;
                        end else begin
                            state <= ST_IDLE;
                        end
                    end
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    // Memory port: a data byte is committed at the fall ending its 8th bit.
    assign mem_we    = (state == ST_WDAT) && byte_done && !start_det && !stop_det;
    assign mem_wdata = shreg;
    assign mem_addr  = ptr;
    assign idle_o    = (state == ST_IDLE);

endmodule

// File: rtl/spd_eeprom.sv
// Top level of the presence-detect EEPROM slave. Synchronizes the bus
// lines, derives edges and START/STOP, and joins the transfer engine to
// the locked byte array. Assumes SCL phases last longer than SYNC_STAGES+1
// clocks.
module spd_eeprom #(
    parameter int                 DEPTH        = spd_pkg::SPD_DEPTH,
    parameter int                 LOCKED_BYTES = 128,
    parameter int                 CSUM_IDX     = 63,
    parameter int                 SYNC_STAGES  = 2,
    parameter logic [3:0]         DEV_PREFIX   = 4'b1010,
    parameter logic [DEPTH*8-1:0] IMAGE        = spd_pkg::spd_default_image()
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       scl_i,
    input  logic       sda_i,
    output logic       sda_o,
    output logic       sda_oe,
    input  logic [2:0] strap_i
);
    localparam int AW = $clog2(DEPTH);

    logic [1:0]    line_now;
    logic [1:0]    line_prev;
    logic          scl_s, sda_s, scl_q, sda_q;
    logic          scl_rise, scl_fall, start_det, stop_det;
    logic [AW-1:0] mem_addr;
    logic          mem_we;
    logic [7:0]    mem_wdata, mem_rdata;
    logic          fsm_idle;

    spd_line_sync #(.WIDTH(2), .STAGES(SYNC_STAGES)) u_sync (
        .clk    (clk),
        .rst_n  (rst_n),
        .d      ({scl_i, sda_i}),
        .q      (line_now),
        .q_prev (line_prev)
    );

    assign {scl_s, sda_s} = line_now;
    assign {scl_q, sda_q} = line_prev;

    // Bus events: SCL edges, and SDA edges while SCL stays high.
    assign scl_rise  =  scl_s && !scl_q;
    assign scl_fall  = !scl_s &&  scl_q;
    assign start_det =  scl_s &&  scl_q &&  sda_q && !sda_s;
    assign stop_det  =  scl_s &&  scl_q && !sda_q &&  sda_s;

    spd_xfer_fsm #(.AW(AW), .STRAP_W(3), .DEV_PREFIX(DEV_PREFIX)) u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .scl_rise  (scl_rise),
        .scl_fall  (scl_fall),
        .sda_s     (sda_s),
        .start_det (start_det),
        .stop_det  (stop_det),
        .strap     (strap_i),
        .rd_data   (mem_rdata),
        .mem_addr  (mem_addr),
        .mem_we    (mem_we),
        .mem_wdata (mem_wdata),
        .sda_drive (sda_oe),
        .idle_o    (fsm_idle)
    );

    spd_store #(
        .DEPTH(DEPTH), .LOCKED_BYTES(LOCKED_BYTES),
        .CSUM_IDX(CSUM_IDX), .IMAGE(IMAGE)
    ) u_store (
        .clk     (clk),
        .rst_n   (rst_n),
        .addr    (mem_addr),
        .wr_en   (mem_we),
        .wr_data (mem_wdata),
        .rd_data (mem_rdata)
    );

    assign sda_o = 1'b0;

endmodule

// File: rtl/spd_eeprom_chk.sv
// Protocol checker for spd_eeprom, bound to every instance of the top.
// Assumes a legal master (SDA stable while SCL high, except START/STOP).
module spd_eeprom_chk (
    input logic clk,
    input logic rst_n,
    input logic scl_s,
    input logic start_det,
    input logic stop_det,
    input logic fsm_idle,
    input logic sda_oe
);

    // R1: the line is released in the first cycle after reset.
    a_r1_reset_release: assert property (@(posedge clk) disable iff (!rst_n)
        $past(!rst_n) |-> !sda_oe);

    // R2: an idle slave (including after a header mismatch) never pulls SDA.
    a_r2_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        fsm_idle |-> !sda_oe);

    // R8: a START releases the line.
    a_r8_start_release: assert property (@(posedge clk) disable iff (!rst_n)
        start_det |=> !sda_oe);

    // R8: a STOP releases the line and parks the engine.
    a_r8_stop_idle: assert property (@(posedge clk) disable iff (!rst_n)
        stop_det |=> (fsm_idle && !sda_oe));

    // R9: the pull-down only changes while SCL is low.
    a_r9_drive_scl_low: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(sda_oe) |-> !scl_s);

endmodule

bind spd_eeprom spd_eeprom_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .scl_s     (scl_s),
    .start_det (start_det),
    .stop_det  (stop_det),
    .fsm_idle  (fsm_idle),
    .sda_oe    (sda_oe)
);

// File: tb/spd_eeprom_tb.sv
// Self-checking bench: a bit-banged bus master with fixed-seed random
// addresses and data plus directed corner cases, against a bench model.
module spd_eeprom_tb;
    timeunit 1ns;
    timeprecision 1ps;

    localparam int Q = 8;   // clocks per quarter bit

    // Bench image: byte i at [8i+7:8i]; byte 63 deliberately wrong.
    function automatic logic [2047:0] build_image();
        logic [2047:0] v;
        v = '0;
        for (int i = 0; i < 256; i++) begin
            logic [7:0] b;
            if (i == 1)       b = 8'h08;
            else if (i == 63) b = 8'hEE;
            else              b = 8'(i * 29 + 7) ^ 8'h96;
            v[i*8 +: 8] = b;
        end
        return v;
    endfunction

    localparam logic [2047:0] TB_IMAGE = build_image();

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       scl = 1'b1;
    logic       m_low = 1'b0;
    logic [2:0] strap = 3'b101;
    logic       sda_o_w, sda_oe_w;
    logic       sda_bus;
    logic [7:0] model [256];
    int         n_checks = 0;
    int         n_err = 0;
    logic       oe_seen = 1'b0;
    logic       oe_bad_edge = 1'b0;
    logic       oe_last = 1'b0;

    assign sda_bus = ~(sda_oe_w | m_low);

    spd_eeprom #(.IMAGE(TB_IMAGE)) u_dut (
        .clk     (clk),
        .rst_n   (rst_n),
        .scl_i   (scl),
        .sda_i   (sda_bus),
        .sda_o   (sda_o_w),
        .sda_oe  (sda_oe_w),
        .strap_i (strap)
    );

    always #2.5 clk = ~clk;

    // Port monitors: any pull seen, and any pull change while SCL is high.
    always @(negedge clk) begin
        if (sda_oe_w) oe_seen <= 1'b1;
        if (rst_n && (sda_oe_w != oe_last) && scl) oe_bad_edge <= 1'b1;
        oe_last <= sda_oe_w;
    end

    function automatic logic [7:0] csum_ref();
        logic [7:0] s;
        s = '0;
        for (int i = 0; i < 63; i++) s = s + TB_IMAGE[i*8 +: 8];
        return s;
    endfunction

    function automatic logic [7:0] dev(input logic rd);
        return {4'b1010, strap, rd};
    endfunction

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic wq(input int n);
        repeat (n * Q) @(negedge clk);
    endtask

    task automatic bus_start();
        m_low = 1'b0; wq(1);
        scl = 1'b1;   wq(2);
        m_low = 1'b1; wq(2);
        scl = 1'b0;   wq(1);
    endtask

    task automatic bus_stop();
        m_low = 1'b1; wq(1);
        scl = 1'b1;   wq(2);
        m_low = 1'b0; wq(2);
    endtask

    task automatic send_bit(input logic b);
        m_low = ~b; wq(1);
        scl = 1'b1; wq(2);
        scl = 1'b0; wq(1);
    endtask

    task automatic recv_bit(output logic b);
        m_low = 1'b0; wq(1);
        scl = 1'b1;   wq(1);
        b = sda_bus;  wq(1);
        scl = 1'b0;   wq(1);
    endtask

    task automatic wr_byte(input logic [7:0] d, output logic ack);
        logic b;
        for (int i = 7; i >= 0; i--) send_bit(d[i]);
        recv_bit(b);
        ack = ~b;
    endtask

    task automatic rd_byte(input logic mack, output logic [7:0] d);
        for (int i = 7; i >= 0; i--) begin
            logic b;
            recv_bit(b);
            d[i] = b;
        end
        send_bit(~mack);
    endtask

    task automatic set_ptr(input logic [7:0] a, input string req);
        logic ack;
        bus_start();
        wr_byte(dev(1'b0), ack); check(req, ack, 1);
        wr_byte(a, ack);         check(req, ack, 1);
    endtask

    task automatic read_run(input logic [7:0] a, input int n, input string req);
        logic       ack;
        logic [7:0] d;
        set_ptr(a, req);
        bus_start();
        wr_byte(dev(1'b1), ack); check(req, ack, 1);
        for (int k = 0; k < n; k++) begin
            rd_byte(k != n - 1, d);
            check(req, d, model[8'(a + k)]);
        end
        bus_stop();
    endtask

    task automatic write_one(input logic [7:0] a, input logic [7:0] d, input string req);
        logic ack;
        set_ptr(a, req);
        wr_byte(d, ack); check(req, ack, 1);
        bus_stop();
        if (a >= 8'd128) model[a] = d;
    endtask

    task automatic summary();
        $display("CHECKS %0d ERRORS %0d", n_checks, n_err);
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        n_err++;
        $display("FAIL watchdog R1 actual hung expected done");
        summary();
        $finish;
    end

    initial begin
        logic       ack;
        logic [7:0] d, a;
        void'($urandom(32'd4242));
        for (int i = 0; i < 256; i++) model[i] = TB_IMAGE[i*8 +: 8];
        model[63] = csum_ref();

        repeat (6) @(negedge clk);
        check("R1 oe during reset", sda_oe_w, 0);
        rst_n = 1'b1;
        repeat (10) @(negedge clk);
        check("R1 oe after reset", sda_oe_w, 0);
        check("R9 sda_o low", sda_o_w, 0);

        // R2: wrong straps and wrong prefix are ignored until START.
        oe_seen = 1'b0;
        bus_start();
        wr_byte({4'b1010, 3'b011, 1'b0}, ack); check("R2 strap mismatch nack", ack, 0);
        wr_byte(8'h00, ack);                   check("R2 idle after mismatch", ack, 0);
        bus_stop();
        bus_start();
        wr_byte({4'b0110, strap, 1'b1}, ack);  check("R2 prefix mismatch nack", ack, 0);
        bus_stop();
        check("R2 no pull after mismatch", oe_seen, 0);

        // R3: random single-byte reads, plus the size byte.
        for (int t = 0; t < 6; t++) read_run(8'($urandom_range(0, 255)), 1, "R3");
        read_run(8'd1, 1, "R3 size byte");

        // R7: checksum slot replaced by the head sum.
        set_ptr(8'd63, "R7");
        bus_start();
        wr_byte(dev(1'b1), ack);
        rd_byte(1'b0, d);
        bus_stop();
        check("R7 checksum", d, csum_ref());

        // R4: sequential read across the 255 -> 0 wrap.
        read_run(8'd253, 6, "R4 wrap read");

        // R5: random writes to the user region, edges included.
        write_one(8'd128, 8'($urandom), "R5");
        write_one(8'd255, 8'($urandom), "R5");
        for (int t = 0; t < 5; t++) write_one(8'($urandom_range(128, 255)), 8'($urandom), "R5");
        read_run(8'd128, 1, "R5 readback");
        read_run(8'd255, 1, "R5 readback");
        for (int t = 0; t < 4; t++) read_run(8'($urandom_range(128, 255)), 2, "R5 readback");

        // R6: locked region acknowledges but keeps its content.
        write_one(8'd0, 8'h5A, "R6");
        write_one(8'd127, 8'hC3, "R6");
        write_one(8'd63, 8'h11, "R6");
        a = 8'($urandom_range(0, 127));
        write_one(a, ~model[a], "R6");
        read_run(8'd0, 1, "R6 unchanged");
        read_run(8'd127, 1, "R6 unchanged");
        read_run(8'd63, 1, "R6 unchanged");
        read_run(a, 1, "R6 unchanged");

        // R4: write wrap 255 -> 0 (0 is locked), and current-address read.
        set_ptr(8'd255, "R4");
        wr_byte(8'h3D, ack); check("R4 wrap write ack", ack, 1);
        wr_byte(8'hA7, ack); check("R4 wrap write ack", ack, 1);
        bus_stop();
        model[255] = 8'h3D;
        read_run(8'd255, 2, "R4 wrap write");
        set_ptr(8'd150, "R4");
        d = 8'($urandom);
        wr_byte(d, ack); check("R4 data ack", ack, 1);
        model[150] = d;
        bus_start();
        wr_byte(dev(1'b1), ack); check("R4 current read ack", ack, 1);
        rd_byte(1'b0, d);
        bus_stop();
        check("R4 current address", d, model[151]);

        // R8: START in mid-byte drops the byte; new header decoded.
        set_ptr(8'd200, "R8");
        for (int i = 0; i < 4; i++) send_bit(1'b1);
        bus_start();
        wr_byte(dev(1'b1), ack); check("R8 header after abort", ack, 1);
        rd_byte(1'b0, d);
        bus_stop();
        check("R8 start abort no write", d, model[200]);

        // R8: STOP in mid-byte drops the byte.
        set_ptr(8'd201, "R8");
        for (int i = 0; i < 3; i++) send_bit(1'b0);
        bus_stop();
        read_run(8'd201, 1, "R8 stop abort no write");

        // R2: new straps take effect, old address no longer answers.
        strap = 3'b010;
        wq(2);
        bus_start();
        wr_byte({4'b1010, 3'b101, 1'b0}, ack); check("R2 old strap nack", ack, 0);
        bus_stop();
        read_run(8'd5, 2, "R2 new strap");

        check("R9 no pull change with SCL high", oe_bad_edge, 0);
        check("R9 sda_o low", sda_o_w, 0);

        summary();
        $finish;
    end

endmodule